// File: doc/BRIEF.md
# Dual-Scan Passive LCD Timing Generator

This block drives the control strobes of a dual-scan colour passive-matrix panel whose 16-bit data path is split into two byte lanes. One lane feeds the upper half of the panel and the other feeds the lower half. A pixel tick is derived from the memory clock by a programmable divisor. Every other timing point is counted in those ticks (Ts). A line consists of a display stretch of (W+1)*8 Ts, a blanking stretch of (B+1)*8 Ts, and 33 Ts of fixed overhead. W is the 7-bit display-width field and B is the 5-bit blanking-width field.

The block produces the line strobe, the frame strobe, the shift clock and the panel's AC-inversion toggle. Byte pairs come from an upstream source through a one-entry request/ready holding stage. Each pair is held on the two lanes around a falling edge of the shift clock. Configuration is sampled at reset and again at each frame boundary, so a field written in the middle of a frame never distorts the frame in progress.

Top module: `lcdt_timing`

## Requirements
- R1: The pixel tick occurs once every (D+1) memory clocks, where D is the 2-bit divisor code (0 selects divide-by-1, 3 selects divide-by-4). All panel outputs change only on the clock edge of a tick. The first tick after reset is the (D+1)-th clock edge after reset is released.
- R2: Each line lasts (W+1)*8 + (B+1)*8 + 33 Ts. The line strobe is high for Ts 0 to 8 of every line.
- R3: The frame strobe rises at Ts 18 of the last line of a frame and falls at Ts 18 of the first line of the next frame. It therefore leads the line strobe's falling edge by one line period minus 9 Ts, and trails it by 9 Ts.
- R4: A frame contains N+1 lines, where N is the line-count field.
- R5: The shift clock runs only during a window from Ts 16 to Ts 16+(W+1)*8-1 of each line. At even offsets into the window it is high, and at odd offsets it is low, giving (W+1)*4 cycles of 2 Ts each. Outside the window it is low.
- R6: A new byte pair appears on the two lanes at each rising edge of the shift clock and is held for 2 Ts. The lanes are zero outside the window. The lanes never change on a falling edge of the shift clock.
- R7: The AC-inversion output toggles exactly once per frame, at Ts (B+1)*8+24 of the last line. It starts low after reset.
- R8: The request output is high exactly when the one-entry holding stage is empty, once the first clock after reset has passed. A pair is taken on a clock where both request and ready are high. If the stage is empty when a shift rising edge needs a pair, the lanes show zero for that pair.
- R9: While reset is high, every output is low. After reset, counting restarts at Ts 0 of line 0 of a frame.
- R10: Changes to the divisor, width, blanking or line-count fields take effect only at the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Pixel-tick divisor code D |
| cfg_hdw | input | HDW_W | Display width field W |
| cfg_hndw | input | HNDW_W | Blanking width field B |
| cfg_lines | input | VL_W | Lines per frame minus one (N) |
| pix_rdy | input | 1 | Upstream has a byte pair on the inputs |
| pix_up_in | input | DW | Upper-half byte from upstream |
| pix_lo_in | input | DW | Lower-half byte from upstream |
| pix_req | output | 1 | Holding stage empty, requesting a pair |
| lcd_frame | output | 1 | Frame strobe |
| lcd_line | output | 1 | Line strobe |
| lcd_shift | output | 1 | Shift clock |
| lcd_mod | output | 1 | AC-inversion toggle |
| lcd_up | output | DW | Upper-half data lane |
| lcd_lo | output | DW | Lower-half data lane |

## Verification
Every panel output is a register loaded on a tick edge. The bench therefore expects a change on the clock edge of the tick itself: a result is due one memory clock after the edge that completed the divisor count, and it stays fixed for the following D clocks. The request output follows the holding stage with no tick involved, one clock after an accept or a pair load. The reference model steps once per memory clock at the falling edge. In that one step it applies the divisor count, the position counters, the queue pop at a shift rising edge and the queue push on request-and-ready. The bench compares every output against the model at that point, away from the edge that moved it. Directed measurements time the line strobe between rising edges in whole clocks, so that each period equals the line length times (D+1).

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // Fixed positions within a line, in pixel ticks
  localparam int LINE_TS  = 9;   // line strobe width
  localparam int FRAME_TS = 18;  // frame strobe edge position
  localparam int WIN_TS   = 16;  // first tick of the shift window
  localparam int MOD_TS   = 24;  // toggle offset past the blanking width
  localparam int PAD_TS   = 33;  // fixed overhead per line
  localparam int UNIT     = 8;   // ticks per field step
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = !rst && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (cnt_q == div)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/lcdt_hv.sv
module lcdt_hv
  import lcdt_pkg::*;
#(
  parameter int DIV_W  = 2,
  parameter int HDW_W  = 7,
  parameter int HNDW_W = 5,
  parameter int VL_W   = 10,
  parameter int HW     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HDW_W-1:0]  cfg_hdw,
  input  logic [HNDW_W-1:0] cfg_hndw,
  input  logic [VL_W-1:0]   cfg_lines,
  output logic [DIV_W-1:0]  div_q,
  output logic [HW-1:0]     h_nxt,
  output logic [VL_W-1:0]   v_nxt,
  output logic [HDW_W-1:0]  hdw_nxt,
  output logic [HNDW_W-1:0] hndw_nxt,
  output logic [VL_W-1:0]   lines_nxt
);
  logic [HW-1:0]     h_q;
  logic [HW-1:0]     last_h;
  logic [VL_W-1:0]   v_q;
  logic [VL_W-1:0]   lines_q;
  logic [HDW_W-1:0]  hdw_q;
  logic [HNDW_W-1:0] hndw_q;
  logic [DIV_W-1:0]  div_nxt;
  logic              run_q;

  // (W+1)*8 + (B+1)*8 + 33 - 1
  assign last_h = HW'({hdw_q, 3'b000}) + HW'({hndw_q, 3'b000})
                + HW'(2 * UNIT + PAD_TS - 1);

  always_comb begin
    h_nxt     = h_q;
    v_nxt     = v_q;
    div_nxt   = div_q;
    hdw_nxt   = hdw_q;
    hndw_nxt  = hndw_q;
    lines_nxt = lines_q;
    if (!run_q) begin
      h_nxt = '0;
      v_nxt = '0;
    end else if (h_q == last_h) begin
      h_nxt = '0;
      if (v_q == lines_q) begin
        v_nxt     = '0;
        div_nxt   = cfg_div;
        hdw_nxt   = cfg_hdw;
        hndw_nxt  = cfg_hndw;
        lines_nxt = cfg_lines;
      end else begin
        v_nxt = v_q + VL_W'(1);
      end
    end else begin
      h_nxt = h_q + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q     <= '0;
      v_q     <= '0;
      run_q   <= 1'b0;
      div_q   <= cfg_div;
      hdw_q   <= cfg_hdw;
      hndw_q  <= cfg_hndw;
      lines_q <= cfg_lines;
    end else if (tick) begin
      h_q     <= h_nxt;
      v_q     <= v_nxt;
      run_q   <= 1'b1;
      div_q   <= div_nxt;
      hdw_q   <= hdw_nxt;
      hndw_q  <= hndw_nxt;
      lines_q <= lines_nxt;
    end
  end
endmodule

// File: rtl/lcdt_pixq.sv
module lcdt_pixq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          rdy,
  input  logic [DW-1:0] up_in,
  input  logic [DW-1:0] lo_in,
  output logic          req,
  output logic [DW-1:0] up_out,
  output logic [DW-1:0] lo_out
);
  logic          armed_q;
  logic          full_q;
  logic [DW-1:0] up_q;
  logic [DW-1:0] lo_q;

  assign req    = armed_q && !full_q;
  assign up_out = full_q ? up_q : '0;
  assign lo_out = full_q ? lo_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      full_q  <= 1'b0;
      up_q    <= '0;
      lo_q    <= '0;
    end else begin
      armed_q <= 1'b1;
      if (take)
        full_q <= 1'b0;
      if (req && rdy) begin
        up_q   <= up_in;
        lo_q   <= lo_in;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
  import lcdt_pkg::*;
#(
  parameter int DIV_W  = 2,
  parameter int HDW_W  = 7,
  parameter int HNDW_W = 5,
  parameter int VL_W   = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HDW_W-1:0]  cfg_hdw,
  input  logic [HNDW_W-1:0] cfg_hndw,
  input  logic [VL_W-1:0]   cfg_lines,
  input  logic              pix_rdy,
  input  logic [DW-1:0]     pix_up_in,
  input  logic [DW-1:0]     pix_lo_in,
  output logic              pix_req,
  output logic              lcd_frame,
  output logic              lcd_line,
  output logic              lcd_shift,
  output logic              lcd_mod,
  output logic [DW-1:0]     lcd_up,
  output logic [DW-1:0]     lcd_lo
);
  localparam int HW = $clog2((2 ** HDW_W) * UNIT + (2 ** HNDW_W) * UNIT + PAD_TS + 1);

  logic              tick;
  logic [DIV_W-1:0]  div_q;
  logic [HW-1:0]     h_nxt;
  logic [VL_W-1:0]   v_nxt;
  logic [HDW_W-1:0]  hdw_nxt;
  logic [HNDW_W-1:0] hndw_nxt;
  logic [VL_W-1:0]   lines_nxt;
  logic [DW-1:0]     q_up;
  logic [DW-1:0]     q_lo;

  lcdt_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk (clk),
    .rst (rst),
    .div (div_q),
    .tick(tick)
  );

  lcdt_hv #(
    .DIV_W (DIV_W),
    .HDW_W (HDW_W),
    .HNDW_W(HNDW_W),
    .VL_W  (VL_W),
    .HW    (HW)
  ) u_hv (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cfg_div  (cfg_div),
    .cfg_hdw  (cfg_hdw),
    .cfg_hndw (cfg_hndw),
    .cfg_lines(cfg_lines),
    .div_q    (div_q),
    .h_nxt    (h_nxt),
    .v_nxt    (v_nxt),
    .hdw_nxt  (hdw_nxt),
    .hndw_nxt (hndw_nxt),
    .lines_nxt(lines_nxt)
  );

  // Decode of the position being entered on this tick
  logic [HW-1:0] hd_n, hn_n, k_n;
  logic          win_n, sh_n, line_n, frame_n, mod_hit, take;

  assign hd_n    = HW'({hdw_nxt, 3'b000}) + HW'(UNIT);
  assign hn_n    = HW'({hndw_nxt, 3'b000}) + HW'(UNIT);
  assign k_n     = h_nxt - HW'(WIN_TS);
  assign win_n   = (h_nxt >= HW'(WIN_TS)) && (h_nxt < hd_n + HW'(WIN_TS));
  assign sh_n    = win_n && !k_n[0];
  assign line_n  = h_nxt < HW'(LINE_TS);
  assign frame_n = ((v_nxt == lines_nxt) && (h_nxt >= HW'(FRAME_TS)))
                || ((v_nxt == '0) && (h_nxt < HW'(FRAME_TS)));
  assign mod_hit = (v_nxt == lines_nxt) && (h_nxt == hn_n + HW'(MOD_TS));
  assign take    = tick && sh_n;

  lcdt_pixq #(.DW(DW)) u_pixq (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .rdy   (pix_rdy),
    .up_in (pix_up_in),
    .lo_in (pix_lo_in),
    .req   (pix_req),
    .up_out(q_up),
    .lo_out(q_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_frame <= 1'b0;
      lcd_line  <= 1'b0;
      lcd_shift <= 1'b0;
      lcd_mod   <= 1'b0;
      lcd_up    <= '0;
      lcd_lo    <= '0;
    end else if (tick) begin
      lcd_frame <= frame_n;
      lcd_line  <= line_n;
      lcd_shift <= sh_n;
      if (mod_hit)
        lcd_mod <= !lcd_mod;
      if (sh_n) begin
        lcd_up <= q_up;
        lcd_lo <= q_lo;
      end else if (!win_n) begin
        lcd_up <= '0;
        lcd_lo <= '0;
      end
    end
  end
endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          pix_req,
  input logic          pix_rdy,
  input logic          lcd_frame,
  input logic          lcd_line,
  input logic          lcd_shift,
  input logic          lcd_mod,
  input logic [DW-1:0] lcd_up,
  input logic [DW-1:0] lcd_lo
);
  // R1: nothing on the panel moves without a pixel tick
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({lcd_frame, lcd_line, lcd_shift, lcd_mod, lcd_up, lcd_lo}));

  // R3: the frame strobe never ends while the line strobe is high
  p_frame_fall_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_frame) |-> !lcd_line);

  // R5: line strobe lies in blanking with the shift clock parked low
  p_line_in_blank_r5: assert property (@(posedge clk) disable iff (rst)
    lcd_line |-> (!lcd_shift && lcd_up == '0 && lcd_lo == '0));

  // R6: lanes are steady across each shift falling edge
  p_lanes_steady_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_shift) |-> ($stable(lcd_up) && $stable(lcd_lo)));

  // R7: the inversion toggle never moves during the line strobe
  p_mod_off_line_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcd_mod) |-> !lcd_line);

  // R8: an accepted pair fills the stage, so the request drops
  p_accept_fills_r8: assert property (@(posedge clk) disable iff (rst)
    (pix_req && pix_rdy) |=> !pix_req);
endmodule

bind lcdt_timing lcdt_timing_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .pix_req  (pix_req),
  .pix_rdy  (pix_rdy),
  .lcd_frame(lcd_frame),
  .lcd_line (lcd_line),
  .lcd_shift(lcd_shift),
  .lcd_mod  (lcd_mod),
  .lcd_up   (lcd_up),
  .lcd_lo   (lcd_lo)
);

// File: tb/tb_lcdt_timing.sv
`timescale 1ns/1ps
module tb_lcdt_timing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_div   = 2'd0;
  logic [6:0] cfg_hdw   = 7'd0;
  logic [4:0] cfg_hndw  = 5'd0;
  logic [9:0] cfg_lines = 10'd2;
  logic       pix_rdy   = 1'b0;
  logic [7:0] pix_up_in = 8'd0;
  logic [7:0] pix_lo_in = 8'd0;
  logic       pix_req, lcd_frame, lcd_line, lcd_shift, lcd_mod;
  logic [7:0] lcd_up, lcd_lo;

  lcdt_timing dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_hdw(cfg_hdw),
    .cfg_hndw(cfg_hndw), .cfg_lines(cfg_lines), .pix_rdy(pix_rdy),
    .pix_up_in(pix_up_in), .pix_lo_in(pix_lo_in), .pix_req(pix_req),
    .lcd_frame(lcd_frame), .lcd_line(lcd_line), .lcd_shift(lcd_shift),
    .lcd_mod(lcd_mod), .lcd_up(lcd_up), .lcd_lo(lcd_lo)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int src = 1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // Behavioural reference, one step per memory clock
  int dcnt, h, v, run, armed;
  int sdiv, shdw, shndw, slines;
  bit e_line, e_frame, e_shift, e_mod, e_req;
  logic [7:0] e_up, e_lo;
  logic [15:0] q[$];

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      dcnt = 0; run = 0; h = 0; v = 0; armed = 0;
      sdiv = cfg_div; shdw = cfg_hdw; shndw = cfg_hndw; slines = cfg_lines;
      e_line = 0; e_frame = 0; e_shift = 0; e_mod = 0; e_req = 0;
      e_up = 0; e_lo = 0;
      q.delete();
    end else begin
      automatic bit req_pre = armed != 0 && q.size() == 0;
      automatic bit tk = (dcnt == sdiv);
      dcnt = tk ? 0 : (dcnt + 1) % 4;
      if (tk) begin
        automatic int hd, hn;
        automatic bit inwin;
        if (run == 0) begin
          run = 1; h = 0; v = 0;
        end else if (h == (shdw + 1) * 8 + (shndw + 1) * 8 + 33 - 1) begin
          h = 0;
          if (v == slines) begin
            v = 0;
            sdiv = cfg_div; shdw = cfg_hdw; shndw = cfg_hndw; slines = cfg_lines;
          end else v++;
        end else h++;
        hd = (shdw + 1) * 8;
        hn = (shndw + 1) * 8;
        e_line  = h < 9;
        e_frame = (v == slines && h >= 18) || (v == 0 && h < 18);
        inwin   = h >= 16 && h < 16 + hd;
        e_shift = inwin && ((h - 16) % 2 == 0);
        if (v == slines && h == hn + 24) e_mod = !e_mod;
        if (e_shift) begin
          if (q.size() > 0) begin
            automatic logic [15:0] pr = q.pop_front();
            e_up = pr[15:8]; e_lo = pr[7:0];
          end else begin
            e_up = 0; e_lo = 0;
          end
        end else if (!inwin) begin
          e_up = 0; e_lo = 0;
        end
      end
      if (req_pre && pix_rdy) begin
        q.push_back({pix_up_in, pix_lo_in});
        src++;
      end
      armed = 1;
      e_req = q.size() == 0;
    end
    if (rst) begin
      chk(!lcd_line && !lcd_frame && !lcd_shift && !lcd_mod && !pix_req
          && lcd_up == 0 && lcd_lo == 0, "R9 outputs in reset",
          {lcd_line, lcd_frame, lcd_shift, lcd_mod, pix_req}, 0);
    end else begin
      chk(lcd_line == e_line, "R2 line strobe", lcd_line, e_line);
      chk(lcd_frame == e_frame, "R3 R4 frame strobe", lcd_frame, e_frame);
      chk(lcd_shift == e_shift, "R5 shift clock", lcd_shift, e_shift);
      chk(lcd_up == e_up && lcd_lo == e_lo, "R6 data lanes",
          {lcd_up, lcd_lo}, {e_up, e_lo});
      chk(lcd_mod == e_mod, "R7 inversion toggle", lcd_mod, e_mod);
      chk(pix_req == e_req, "R8 request", pix_req, e_req);
    end
  end

  // Upstream source
  always @(negedge clk) begin
    #2;
    case (rdy_mode)
      0: pix_rdy <= 1'b1;
      1: pix_rdy <= (cyc % 50) >= 20;
      default: pix_rdy <= (cyc % 13) >= 6;
    endcase
    pix_up_in <= src[7:0];
    pix_lo_in <= ~src[7:0] ^ src[15:8];
  end

  task automatic measure_line(input int exp_clk, input string tag);
    int t0;
    @(posedge lcd_line);
    t0 = cyc;
    @(posedge lcd_line);
    chk(cyc - t0 == exp_clk, tag, cyc - t0, exp_clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    nchk++;
    nfail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", cyc);
    finish_up();
  end

  initial begin
    // Set A: D=0, W=0, B=0, 3 lines -> 49 Ts per line
    step(4);
    rst = 1'b0;
    measure_line(49, "R1 R2 line period, divide-by-1");

    // Mid-frame change: must not touch the frame in progress (R10)
    @(negedge lcd_frame);
    step(1);
    cfg_div = 2'd2; cfg_hdw = 7'd1; cfg_hndw = 5'd2; cfg_lines = 10'd1;
    rdy_mode = 1;
    measure_line(49, "R10 old line period kept until frame end");
    // Next frame: 16+24+33 = 73 Ts, 3 clocks each
    measure_line(219, "R1 R2 R10 line period, divide-by-3");
    step(1500);

    // Set C: D=3, W=3, B=1, 4 lines, bursty source with underruns
    cfg_div = 2'd3; cfg_hdw = 7'd3; cfg_hndw = 5'd1; cfg_lines = 10'd3;
    rdy_mode = 2;
    step(500);
    measure_line(324, "R1 R2 line period, divide-by-4");
    step(3500);

    // Reset mid-run, then the widest display with divide-by-2
    rst = 1'b1;
    cfg_div = 2'd1; cfg_hdw = 7'd127; cfg_hndw = 5'd0; cfg_lines = 10'd1;
    rdy_mode = 0;
    step(3);
    rst = 1'b0;
    measure_line(2130, "R1 R2 R9 widest line, divide-by-2");
    step(2500);
    finish_up();
  end
endmodule